// File: doc/BRIEF.md
# Vector Predication State Advance Unit

This block keeps the 32-bit vector predication register of a beat-wise vector pipeline. It updates that register once when a vector instruction retires. The predicate field is 16 bits wide and gives four lanes to each of four beats. Two 4-bit mask fields record how the remaining instructions of a predicated block should treat the predicate. When the instruction ends, the unit inverts the predicate bits of a half if that half's mask field asks for it, and then shifts the mask fields left by one. Both actions are restricted to the beats the instruction actually ran.

A 3-bit continuation code reports how many leading beats of the instruction were already completed before a resume. Those beats are treated as not executed here, and their predicate bits and mask updates are left alone. Software-visible writes of the register come in through a load port. Decode, lane arithmetic and the rules that build the predicate are outside this block.

Each cycle the unit selects one of three operations. The selection is a priority choice, shown below in priority order:

| Operation | Condition | Effect on the register |
|---|---|---|
| LOAD | `load_en` high | Takes `load_val` |
| ADVANCE | `adv_en` high and `load_en` low | Applies the gated inversion and the mask shift |
| HOLD | both strobes low | Keeps its value |

Top module: `pva_unit`

## Requirements
- R1: While `rst_n` is low, the register `vpr_q` is cleared to zero.
- R2: In a cycle with `load_en` and `adv_en` both low, `vpr_q` keeps its value at the next clock edge.
- R3: In a cycle with `load_en` high, `vpr_q` equals `load_val` after the next clock edge, whatever the value of `adv_en`. A load takes priority over an advance.
- R4: Predicate bits [4b+3:4b] belong to beat b. The code values and the beats they mark as executed are: 0 runs beats 0-3; 1 runs beats 1-3; 2 runs beats 2-3; 3 runs beat 3 only; 4 runs beat 3 only. Codes 5, 6 and 7 are treated like code 0. On an advance, the predicate bits of beats that were not executed are left unchanged.
- R5: On an advance, the executed-beat bits within predicate bits [7:0] are inverted exactly when the low mask field `vpr_q[19:16]` is greater than 8. Otherwise they are left unchanged.
- R6: On an advance, the executed-beat bits within predicate bits [15:8] are inverted exactly when the high mask field `vpr_q[23:20]` is greater than 8. Otherwise they are left unchanged.
- R7: On an advance, the low mask field is shifted left by one if beat 1 was executed. Its top bit is discarded and a zero enters at the bottom. If beat 1 was not executed, the field is left unchanged.
- R8: On an advance, the high mask field is always shifted left by one. Its top bit is discarded and a zero enters at the bottom.
- R9: On an advance, bits [31:24] of `vpr_q` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update happens on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write strobe for the register |
| load_val | input | 32 | Value written when `load_en` is high |
| adv_en | input | 1 | End-of-instruction advance strobe |
| cont_code | input | 3 | Continuation code that reports the beats already completed |
| vpr_q | output | 32 | Current register value |

## Verification
Two functions can meet in one cycle: a load and an advance. The bench drives `load_en` and `adv_en` high in the same cycle, on a register that holds non-trivial masks, so an advance would visibly change it. It then judges that the next value is exactly the loaded word. The other functions also meet within one advance: predicate inversion and mask shifting both read the pre-update mask fields in a single edge. The bench sweeps every pair of mask values against all eight continuation codes. It compares each field on its own, so a shift that leaked into the inversion decision would show up as a field mismatch.

// File: rtl/pva_pkg.sv
package pva_pkg;

    typedef enum logic [2:0] {
        CONT_NONE      = 3'd0,
        CONT_B0        = 3'd1,
        CONT_B01       = 3'd2,
        CONT_B012      = 3'd3,
        CONT_B012_NEXT = 3'd4
    } cont_e;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_LOAD    = 2'd1,
        OP_ADVANCE = 2'd2
    } op_e;

endpackage

// File: rtl/pva_beat_decode.sv
module pva_beat_decode #(
    parameter int BEATS     = 4,
    parameter int LANE_BITS = 4,
    parameter int CODE_W    = 3
) (
    input  logic [CODE_W-1:0]          code,
    output logic [BEATS-1:0]           beat_run,
    output logic [BEATS*LANE_BITS-1:0] lane_run
);
    import pva_pkg::*;

    int done_cnt;

    // number of leading beats already completed before this pass
    always_comb begin
        case (cont_e'(code))
            CONT_B0:        done_cnt = 1;
            CONT_B01:       done_cnt = 2;
            CONT_B012:      done_cnt = 3;
            CONT_B012_NEXT: done_cnt = 3;
            default:        done_cnt = 0;
        endcase
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        assign beat_run[b] = (b >= done_cnt);
        assign lane_run[b*LANE_BITS +: LANE_BITS] = {LANE_BITS{beat_run[b]}};
    end

endmodule

// File: rtl/pva_pred_invert.sv
module pva_pred_invert #(
    parameter int BEATS     = 4,
    parameter int LANE_BITS = 4,
    parameter int MASK_W    = 4
) (
    input  logic [BEATS*LANE_BITS-1:0] pred_in,
    input  logic [MASK_W-1:0]          mask_lo,
    input  logic [MASK_W-1:0]          mask_hi,
    input  logic [BEATS*LANE_BITS-1:0] lane_run,
    output logic [BEATS*LANE_BITS-1:0] pred_out
);
    localparam int HALF_BEATS = BEATS / 2;
    localparam logic [MASK_W-1:0] TOP_ONLY = MASK_W'(1) << (MASK_W - 1);

    logic flip_lo;
    logic flip_hi;

    // a half flips when its mask has the top bit set and is not the lone top bit
    assign flip_lo = (mask_lo > TOP_ONLY);
    assign flip_hi = (mask_hi > TOP_ONLY);

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        logic sel;
        if (b < HALF_BEATS) begin : g_lo
            assign sel = flip_lo;
        end else begin : g_hi
            assign sel = flip_hi;
        end
        assign pred_out[b*LANE_BITS +: LANE_BITS] =
            pred_in[b*LANE_BITS +: LANE_BITS] ^
            (lane_run[b*LANE_BITS +: LANE_BITS] & {LANE_BITS{sel}});
    end

endmodule

// File: rtl/pva_mask_shift.sv
module pva_mask_shift #(
    parameter int BEATS  = 4,
    parameter int MASK_W = 4
) (
    input  logic [MASK_W-1:0] mask_lo_in,
    input  logic [MASK_W-1:0] mask_hi_in,
    input  logic [BEATS-1:0]  beat_run,
    output logic [MASK_W-1:0] mask_lo_out,
    output logic [MASK_W-1:0] mask_hi_out
);
    // the low field belongs to the last beat of the lower half
    localparam int LO_OWNER = BEATS / 2 - 1;

    assign mask_lo_out = beat_run[LO_OWNER] ? {mask_lo_in[MASK_W-2:0], 1'b0} : mask_lo_in;
    assign mask_hi_out = {mask_hi_in[MASK_W-2:0], 1'b0};

endmodule

// File: rtl/pva_unit.sv
module pva_unit #(
    parameter int BEATS     = 4,
    parameter int LANE_BITS = 4,
    parameter int MASK_W    = 4,
    parameter int REG_W     = 32,
    parameter int CODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [REG_W-1:0]  load_val,
    input  logic              adv_en,
    input  logic [CODE_W-1:0] cont_code,
    output logic [REG_W-1:0]  vpr_q
);
    import pva_pkg::*;

    localparam int PRED_W    = BEATS * LANE_BITS;
    localparam int MASK0_LSB = PRED_W;
    localparam int MASK1_LSB = PRED_W + MASK_W;
    localparam int UPPER_LSB = PRED_W + 2 * MASK_W;
    localparam int UPPER_W   = REG_W - UPPER_LSB;
    localparam int SKIP3_W   = (BEATS - 1) * LANE_BITS;
    localparam logic [MASK_W-1:0] TOP_ONLY = MASK_W'(1) << (MASK_W - 1);

    op_e               op;
    logic [REG_W-1:0]  vpr_d;
    logic [REG_W-1:0]  adv_val;
    logic [BEATS-1:0]  beat_run;
    logic [PRED_W-1:0] lane_run;
    logic [PRED_W-1:0] pred_new;
    logic [MASK_W-1:0] mlo_new;
    logic [MASK_W-1:0] mhi_new;

    pva_beat_decode #(.BEATS(BEATS), .LANE_BITS(LANE_BITS), .CODE_W(CODE_W)) u_dec (
        .code     (cont_code),
        .beat_run (beat_run),
        .lane_run (lane_run)
    );

    pva_pred_invert #(.BEATS(BEATS), .LANE_BITS(LANE_BITS), .MASK_W(MASK_W)) u_inv (
        .pred_in  (vpr_q[PRED_W-1:0]),
        .mask_lo  (vpr_q[MASK0_LSB +: MASK_W]),
        .mask_hi  (vpr_q[MASK1_LSB +: MASK_W]),
        .lane_run (lane_run),
        .pred_out (pred_new)
    );

    pva_mask_shift #(.BEATS(BEATS), .MASK_W(MASK_W)) u_shf (
        .mask_lo_in  (vpr_q[MASK0_LSB +: MASK_W]),
        .mask_hi_in  (vpr_q[MASK1_LSB +: MASK_W]),
        .beat_run    (beat_run),
        .mask_lo_out (mlo_new),
        .mask_hi_out (mhi_new)
    );

    assign adv_val = {vpr_q[REG_W-1:UPPER_LSB], mhi_new, mlo_new, pred_new};

    // operation select: load outranks advance
    always_comb begin
        if (load_en)     op = OP_LOAD;
        else if (adv_en) op = OP_ADVANCE;
        else             op = OP_HOLD;
    end

    always_comb begin
        unique case (op)
            OP_LOAD:    vpr_d = load_val;
            OP_ADVANCE: vpr_d = adv_val;
            default:    vpr_d = vpr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpr_q <= '0;
        else        vpr_q <= vpr_d;
    end

    // ---------------- assertions ----------------
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || vpr_q == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !adv_en) |=> $stable(vpr_q));

    p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> vpr_q == $past(load_val));

    p_skip_done_beats_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en && cont_code == CONT_B012)
        |=> vpr_q[SKIP3_W-1:0] == $past(vpr_q[SKIP3_W-1:0]));

    p_low_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en && vpr_q[MASK0_LSB +: MASK_W] <= TOP_ONLY)
        |=> vpr_q[PRED_W/2-1:0] == $past(vpr_q[PRED_W/2-1:0]));

    p_high_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en && vpr_q[MASK1_LSB +: MASK_W] <= TOP_ONLY)
        |=> vpr_q[PRED_W-1:PRED_W/2] == $past(vpr_q[PRED_W-1:PRED_W/2]));

    p_mask_hi_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en)
        |=> vpr_q[MASK1_LSB +: MASK_W] == {$past(vpr_q[MASK1_LSB +: MASK_W-1]), 1'b0});

    p_upper_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en)
        |=> vpr_q[REG_W-1 -: UPPER_W] == $past(vpr_q[REG_W-1 -: UPPER_W]));

endmodule

// File: tb/test_pva_unit.sv
`timescale 1ns/1ps
module test_pva_unit;

    typedef struct {
        logic [31:0] exp;
        int          kind;   // 0 hold, 1 load, 2 advance
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_val = '0;
    logic        adv_en = 1'b0;
    logic [2:0]  cont_code = '0;
    logic [31:0] vpr_q;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];
    logic [31:0] shadow = '0;

    always #5 clk = ~clk;

    pva_unit i_pva_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_val  (load_val),
        .adv_en    (adv_en),
        .cont_code (cont_code),
        .vpr_q     (vpr_q)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // independent model of one advance, written from the requirements
    function automatic logic [31:0] adv_model(logic [31:0] v, int code);
        int done;
        logic [31:0] r;
        logic [3:0] m0, m1;
        case (code)
            1: done = 1;
            2: done = 2;
            3, 4: done = 3;
            default: done = 0;
        endcase
        m0 = v[19:16];
        m1 = v[23:20];
        r = v;
        for (int b = 0; b < 4; b++) begin
            if (b >= done) begin
                if ((b < 2 && m0 > 4'd8) || (b >= 2 && m1 > 4'd8))
                    r[b*4 +: 4] = ~v[b*4 +: 4];
            end
        end
        if (done <= 1) r[19:16] = {m0[2:0], 1'b0};
        r[23:20] = {m1[2:0], 1'b0};
        return r;
    endfunction

    task automatic drive(bit ld, logic [31:0] d, bit adv, int code);
        item_t it;
        @(negedge clk);
        load_en   = ld;
        load_val  = d;
        adv_en    = adv;
        cont_code = 3'(code);
        if (ld)       begin it.exp = d;                        it.kind = 1; end
        else if (adv) begin it.exp = adv_model(shadow, code);  it.kind = 2; end
        else          begin it.exp = shadow;                   it.kind = 0; end
        shadow = it.exp;
        sb_q.push_back(it);
    endtask

    // monitor: compare one expected item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                case (it.kind)
                    0: chk("R2 hold", vpr_q, it.exp);
                    1: chk("R3 load", vpr_q, it.exp);
                    default: begin
                        chk("R4/R5 low predicate half", {24'h0, vpr_q[7:0]}, {24'h0, it.exp[7:0]});
                        chk("R4/R6 high predicate half", {24'h0, vpr_q[15:8]}, {24'h0, it.exp[15:8]});
                        chk("R7 low mask field", {28'h0, vpr_q[19:16]}, {28'h0, it.exp[19:16]});
                        chk("R8 high mask field", {28'h0, vpr_q[23:20]}, {28'h0, it.exp[23:20]});
                        chk("R9 upper bits", {24'h0, vpr_q[31:24]}, {24'h0, it.exp[31:24]});
                    end
                endcase
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset value", vpr_q, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", vpr_q, 32'h0);

        // hold after load
        drive(1, 32'h12F9_ABCD, 0, 0);
        drive(0, 32'hFFFF_FFFF, 0, 0);
        drive(0, 32'h0, 0, 7);

        // collision: load and advance together, load must win (R3)
        drive(1, 32'h77FA_0F0F, 0, 0);
        drive(1, 32'h3CA9_5A5A, 1, 0);
        drive(0, 32'h0, 0, 0);

        // back-to-back advances walk the masks out
        drive(1, 32'h00FF_1234, 0, 0);
        for (int k = 0; k < 5; k++) drive(0, 32'h0, 1, 0);

        // full sweep: every mask pair against all eight codes
        for (int m0 = 0; m0 < 16; m0++) begin
            for (int m1 = 0; m1 < 16; m1++) begin
                for (int c = 0; c < 8; c++) begin
                    logic [31:0] v;
                    v[15:0]  = 16'hC3A5 ^ 16'(m0 << 8) ^ 16'(m1 << 4) ^ 16'(c);
                    v[19:16] = 4'(m0);
                    v[23:20] = 4'(m1);
                    v[31:24] = 8'(m0 * 16 + m1) ^ 8'h5A;
                    drive(1, v, 0, 0);
                    drive(0, 32'h0, 1, c);
                end
            end
        end

        drive(0, 32'h0, 0, 0);
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule